// File: doc/BRIEF.md
# External Interrupt Request Combiner

This block merges several external event sources into a single interrupt request line for a processor. The first source is a dedicated interrupt pin that is active low. The second is a group of general-purpose port pins that are active high and share that pin's request. The third is one further port pin that only reacts to a falling edge. The dedicated pin and the port group feed one "shared" source. The extra pin is a separate source with its own enable, flag and acknowledge bits. Both sets of bits live in one 8-bit control/status register.

Build-time parameters set three things: whether the port group is wired into the shared source at all, whether the shared source is edge-only or edge-and-level sensitive, and the depth of the input synchronisers. Every external input is brought into the clock domain through a synchroniser before any level or edge detection. The port pins are ORed together before the edge detector. So while one of them is held high, rising edges on the others produce no new event.

Software enables a source, reads its flag, and clears the flag by writing 1 to its acknowledge bit. The request output is combinational from registered state. The processor's vectoring and stacking happen elsewhere.

Top module: `ext_irq_combiner`

## Requirements
- R1: With the default depth of two, an input change first reaches the level path after two rising clock edges, and it sets a flag on the third rising clock edge.
- R2: A falling edge on the dedicated pin `irq_pin_n` sets the shared flag (register bit 1). In edge-and-level mode, a low level on this pin also drives the request directly while the shared enable is set.
- R3: When `PORT_IRQ_EN` is 1, a rising edge on any port pin sets the shared flag. When it is 0, the port pins have no effect on the flag or the request.
- R4: With `LEVEL_MODE` = 1, an active shared level (a port pin high or the dedicated pin low) raises `cpu_irq` as soon as it is synchronised, before the flag is set. With `LEVEL_MODE` = 0, only the flag raises it.
- R5: The port pins are ORed before edge detection. While any one of them stays high, a rising edge on another does not set the shared flag.
- R6: A falling edge on `extra_pin` sets the extra flag (bit 5). A rising edge on it sets nothing.
- R7: Register layout, identical for read and write:
  - bit 0: shared enable (read/write)
  - bit 1: shared flag (read-only)
  - bit 2: shared acknowledge (write-only, reads 0)
  - bit 4: extra enable (read/write)
  - bit 5: extra flag (read-only)
  - bit 6: extra acknowledge (write-only, reads 0)
  - bits 3 and 7 read 0.
  Every write loads both enables.
- R8: Writing 1 to an acknowledge bit clears the matching flag. If a new edge for that source arrives in the same cycle, the flag stays set. With no edge and no acknowledge, a flag keeps its value.
- R9: `cpu_irq` = (shared enable AND (shared flag OR (`LEVEL_MODE` AND active shared level))) OR (extra enable AND extra flag).
- R10: Reset clears both enables and both flags. Flags are still set while their enable is clear, but they do not raise `cpu_irq` then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Dedicated interrupt pin, active low |
| port_pins | input | NUM_PORT | Port pins sharing the interrupt, active high |
| extra_pin | input | 1 | Extra port pin, falling-edge source |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data |
| cpu_irq | output | 1 | Combined interrupt request to the processor |

## Verification
The assertions assume that an acknowledge write and a new edge are the only events that change a flag. They also assume that register writes last exactly one cycle. They do not model how the pins behave between clock edges, so the stimulus changes pins only on the falling clock edge and holds each pattern long enough for the synchroniser to settle. Each write strobe is held for exactly one cycle. The stimulus places one acknowledge deliberately in the cycle where an edge is being detected, to cover the collision. It also sweeps every non-zero pattern of the four port pins. Three instances with different build options receive the same pins, so each pattern is checked against all three sensitivity variants.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

    localparam int CSR_W  = 8;
    localparam int B_SEN  = 0;
    localparam int B_SFLG = 1;
    localparam int B_SACK = 2;
    localparam int B_XEN  = 4;
    localparam int B_XFLG = 5;
    localparam int B_XACK = 6;

    typedef struct packed {
        logic shr_en;
        logic shr_flag;
        logic xtr_en;
        logic xtr_flag;
    } csr_state_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter bit   RISING  = 1'b1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic pulse
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = sig & ~prev_q;
        end else begin : g_fall
            assign pulse = ~sig & prev_q;
        end
    endgenerate

endmodule

// File: rtl/irq_csr.sv
module irq_csr
    import irq_comb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shr_set,
    input  logic             xtr_set,
    input  logic             wr,
    input  logic [CSR_W-1:0] wdata,
    output csr_state_t       state,
    output logic [CSR_W-1:0] rdata
);

    csr_state_t st_d, st_q;
    logic       unused_wbits;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.shr_en = wdata[B_SEN];
            st_d.xtr_en = wdata[B_XEN];
            if (wdata[B_SACK]) st_d.shr_flag = 1'b0;
            if (wdata[B_XACK]) st_d.xtr_flag = 1'b0;
        end
        // a fresh edge wins over an acknowledge in the same cycle
        if (shr_set) st_d.shr_flag = 1'b1;
        if (xtr_set) st_d.xtr_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata         = '0;
        rdata[B_SEN]  = st_q.shr_en;
        rdata[B_SFLG] = st_q.shr_flag;
        rdata[B_XEN]  = st_q.xtr_en;
        rdata[B_XFLG] = st_q.xtr_flag;
    end

    assign state        = st_q;
    assign unused_wbits = ^{wdata[7], wdata[5], wdata[3], wdata[1]};

endmodule

// File: rtl/ext_irq_combiner.sv
module ext_irq_combiner
    import irq_comb_pkg::*;
#(
    parameter int NUM_PORT    = 4,
    parameter bit PORT_IRQ_EN = 1'b1,
    parameter bit LEVEL_MODE  = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_pin_n,
    input  logic [NUM_PORT-1:0] port_pins,
    input  logic                extra_pin,
    input  logic                csr_wr,
    input  logic [7:0]          csr_wdata,
    output logic [7:0]          csr_rdata,
    output logic                cpu_irq
);

    localparam int             IN_W    = NUM_PORT + 2;
    localparam int             IDX_XTR = NUM_PORT + 1;
    localparam logic [IN_W-1:0] IN_IDLE = {1'b1, {NUM_PORT{1'b0}}, 1'b1};

    logic [IN_W-1:0] raw_in, sync_in;
    logic            port_any;
    logic            shr_act;
    logic            shr_rise;
    logic            xtr_fall;
    csr_state_t      state;

    assign raw_in = {extra_pin, port_pins, irq_pin_n};

    irq_sync #(
        .WIDTH  (IN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IN_IDLE)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_in)
    );

    generate
        if (PORT_IRQ_EN) begin : g_port
            assign port_any = |sync_in[NUM_PORT:1];
        end else begin : g_noport
            logic unused_port;
            assign unused_port = |sync_in[NUM_PORT:1];
            assign port_any    = 1'b0;
        end
    endgenerate

    assign shr_act = ~sync_in[0] | port_any;

    irq_edge_det #(
        .RISING (1'b1),
        .RST_VAL(1'b0)
    ) i_shr_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (shr_act),
        .pulse(shr_rise)
    );

    irq_edge_det #(
        .RISING (1'b0),
        .RST_VAL(1'b1)
    ) i_xtr_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (sync_in[IDX_XTR]),
        .pulse(xtr_fall)
    );

    irq_csr i_csr (
        .clk    (clk),
        .rst_n  (rst_n),
        .shr_set(shr_rise),
        .xtr_set(xtr_fall),
        .wr     (csr_wr),
        .wdata  (csr_wdata),
        .state  (state),
        .rdata  (csr_rdata)
    );

    always_comb begin
        cpu_irq = (state.shr_en & (state.shr_flag | (LEVEL_MODE & shr_act)))
                | (state.xtr_en & state.xtr_flag);
    end

endmodule

// File: rtl/irq_comb_chk.sv
module irq_comb_chk
    import irq_comb_pkg::*;
#(
    parameter bit LEVEL_MODE = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       shr_rise,
    input logic       xtr_fall,
    input logic       csr_wr,
    input logic [7:0] csr_wdata,
    input logic [7:0] csr_rdata,
    input logic       cpu_irq
);

    AST_SHR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        shr_rise |=> csr_rdata[B_SFLG]); // R2

    AST_XTR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        xtr_fall |=> csr_rdata[B_XFLG]); // R6

    AST_SHR_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_wdata[B_SACK] && !shr_rise) |=> !csr_rdata[B_SFLG]); // R8

    AST_XTR_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_wdata[B_XACK] && !xtr_fall) |=> !csr_rdata[B_XFLG]); // R8

    AST_SHR_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!shr_rise && !(csr_wr && csr_wdata[B_SACK])) |=> $stable(csr_rdata[B_SFLG])); // R8

    AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_rdata[B_SEN] && !csr_rdata[B_XEN]) |-> !cpu_irq); // R10

    AST_XTR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[B_XEN] && csr_rdata[B_XFLG]) |-> cpu_irq); // R9

    AST_EDGE_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!LEVEL_MODE && cpu_irq) |->
            ((csr_rdata[B_SEN] && csr_rdata[B_SFLG]) ||
             (csr_rdata[B_XEN] && csr_rdata[B_XFLG]))); // R4

    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[7] == 1'b0) && (csr_rdata[3] == 1'b0) &&
        (csr_rdata[B_SACK] == 1'b0) && (csr_rdata[B_XACK] == 1'b0)); // R7

endmodule

bind ext_irq_combiner irq_comb_chk #(.LEVEL_MODE(LEVEL_MODE)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shr_rise (shr_rise),
    .xtr_fall (xtr_fall),
    .csr_wr   (csr_wr),
    .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata),
    .cpu_irq  (cpu_irq)
);

// File: tb/test_ext_irq_combiner.sv
module test_ext_irq_combiner;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_n = 1'b1;
    logic [3:0] port = 4'h0;
    logic       extra = 1'b1;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rd_a, rd_b, rd_c;
    logic       irq_a, irq_b, irq_c;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    // level-sensitive, ports connected
    ext_irq_combiner #(.NUM_PORT(4), .PORT_IRQ_EN(1'b1), .LEVEL_MODE(1'b1)) i_ext_irq_combiner (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_n), .port_pins(port), .extra_pin(extra),
        .csr_wr(wr), .csr_wdata(wdata), .csr_rdata(rd_a), .cpu_irq(irq_a));

    // edge-only, ports connected
    ext_irq_combiner #(.NUM_PORT(4), .PORT_IRQ_EN(1'b1), .LEVEL_MODE(1'b0)) i_ext_irq_combiner_edge (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_n), .port_pins(port), .extra_pin(extra),
        .csr_wr(wr), .csr_wdata(wdata), .csr_rdata(rd_b), .cpu_irq(irq_b));

    // level-sensitive, ports not connected
    ext_irq_combiner #(.NUM_PORT(4), .PORT_IRQ_EN(1'b0), .LEVEL_MODE(1'b1)) i_ext_irq_combiner_noport (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_n), .port_pins(port), .extra_pin(extra),
        .csr_wr(wr), .csr_wdata(wdata), .csr_rdata(rd_c), .cpu_irq(irq_c));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_csr(input logic [7:0] d);
        wr    = 1'b1;
        wdata = d;
        @(negedge clk);
        wr    = 1'b0;
        wdata = 8'h00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R10: reset state
        chk("R10 reset rd_a", rd_a, 8'h00);
        chk("R10 reset rd_b", rd_b, 8'h00);
        chk("R10 reset irq", {5'd0, irq_a, irq_b, irq_c}, 8'h00);

        // R7: ack bits and unused bits read 0, enables load on every write
        wr_csr(8'hFF);
        chk("R7 write FF readback", rd_a, 8'h11);
        wr_csr(8'h01);
        chk("R7 shared enable only", rd_a, 8'h01);

        // R1/R2/R4: dedicated pin
        irq_n = 1'b0;
        tick(1);
        chk("R1 one edge no level", {7'd0, irq_a}, 8'h00);
        tick(1);
        chk("R1 R4 level after two edges", {7'd0, irq_a}, 8'h01);
        chk("R4 edge-only no request yet", {7'd0, irq_b}, 8'h00);
        chk("R1 flag not yet set", rd_a, 8'h01);
        tick(1);
        chk("R2 shared flag set", rd_a, 8'h03);
        chk("R2 edge-only request", {7'd0, irq_b}, 8'h01);
        chk("R2 no-port instance flag", rd_c, 8'h03);
        irq_n = 1'b1;
        tick(3);
        chk("R9 flag holds request", {5'd0, irq_a, irq_b, irq_c}, 8'h07);
        wr_csr(8'h05);
        chk("R8 ack clears flag", rd_a, 8'h01);
        chk("R8 ack clears request", {5'd0, irq_a, irq_b, irq_c}, 8'h00);

        // R3/R4: sweep every port pattern
        for (int p = 1; p < 16; p++) begin
            port = p[3:0];
            tick(2);
            chk("R4 level request on port", {7'd0, irq_a}, 8'h01);
            chk("R4 edge-only waits for flag", {7'd0, irq_b}, 8'h00);
            tick(1);
            chk("R3 port rising sets flag A", rd_a, 8'h03);
            chk("R3 port rising sets flag B", rd_b, 8'h03);
            chk("R3 unconnected ports ignored", rd_c, 8'h01);
            chk("R3 unconnected no request", {7'd0, irq_c}, 8'h00);
            port = 4'h0;
            tick(3);
            chk("R9 edge flag holds request", {7'd0, irq_b}, 8'h01);
            wr_csr(8'h05);
            chk("R8 ack after sweep", rd_b, 8'h01);
        end

        // R5: OR before edge detection
        port = 4'h1;
        tick(3);
        wr_csr(8'h05);
        chk("R5 flags cleared with pin high", rd_b, 8'h01);
        port = 4'h3;
        tick(3);
        chk("R5 second pin rise masked B", rd_b, 8'h01);
        chk("R5 second pin rise masked A", rd_a, 8'h01);
        port = 4'h2;
        tick(3);
        chk("R5 first pin fall no event", rd_b, 8'h01);
        port = 4'h0;
        tick(3);
        port = 4'h2;
        tick(3);
        chk("R5 rise from all-low sets flag", rd_b, 8'h03);
        port = 4'h0;
        tick(3);
        wr_csr(8'h05);

        // R8: acknowledge collides with a new edge
        irq_n = 1'b0;
        tick(2);
        wr_csr(8'h05);
        chk("R8 edge wins over ack A", rd_a, 8'h03);
        chk("R8 edge wins over ack C", rd_c, 8'h03);
        irq_n = 1'b1;
        tick(3);
        wr_csr(8'h05);
        chk("R8 later ack clears", rd_a, 8'h01);

        // R6/R10/R9: extra pin
        extra = 1'b0;
        tick(3);
        chk("R6 falling edge sets extra flag", rd_a, 8'h21);
        chk("R10 flag without enable no request", {7'd0, irq_a}, 8'h00);
        wr_csr(8'h11);
        chk("R9 extra enable raises request", {5'd0, irq_a, irq_b, irq_c}, 8'h07);
        wr_csr(8'h51);
        chk("R8 extra ack clears", rd_a, 8'h11);
        chk("R8 extra ack drops request", {7'd0, irq_b}, 8'h00);
        extra = 1'b1;
        tick(3);
        chk("R6 rising edge ignored", rd_a, 8'h11);

        // R9/R10: shared flag with enable cleared
        irq_n = 1'b0;
        tick(3);
        wr_csr(8'h00);
        chk("R10 flag readable while disabled", rd_a, 8'h02);
        chk("R9 level gated by enable", {5'd0, irq_a, irq_b, irq_c}, 8'h00);
        irq_n = 1'b1;
        tick(3);
        wr_csr(8'h04);
        chk("R8 ack while disabled", rd_a, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule